// File: doc/BRIEF.md
# Byte Program-and-Verify Sequencer

This block is a host-side controller that writes a run of bytes into a programmable non-volatile memory and confirms the result. A start request supplies a base address and a byte count. For each address the block takes the wanted byte from a source-data request port. It then raises the supply-raise and high-voltage flags, applies a timed write strobe and reads the byte back with the output enable low. It repeats the pulse until the byte matches or the per-address pulse limit is used up.

After every address has passed, the block drops the raised supply and makes a second pass over the whole range. In that pass it fetches each source byte again and compares it with the memory content read at nominal supply. The result is reported as a one-cycle done pulse together with a held pass or fail flag and the first failing address. All durations are counted in clock cycles and derived from a clock-frequency parameter. The block does not generate any voltage and does not contain the memory array.

Top module: `pvs_seq`

## Requirements
- R1: Every write strobe stays high for exactly PULSE_CYC = CLK_MHZ*PULSE_US consecutive clock cycles (50 us by default).
- R2: The strobe is high only while mem_vpp and mem_vraise are both high. mem_vpp is high for at least SETUP_CYC = CLK_MHZ*SETUP_US cycles before the strobe rises and stays high for at least SETUP_CYC cycles after it falls. mem_addr and mem_dout do not change during that window.
- R3: A verify read holds mem_oe_n low for RD_CYC cycles with mem_vpp and mem_strobe low, and compares mem_din in the last of those cycles.
- R4: A byte that does not match after a pulse gets another pulse. No address receives more than RETRY_MAX (25) pulses. A mismatch after the last allowed pulse ends the run with fail set and fail_addr equal to that address, and no further strobe is issued.
- R5: The pulse count starts from zero at each new address, so the limit applies to each address separately.
- R6: Once the last address has verified, mem_vraise goes low and every address from the base upward is read again and compared with a freshly fetched source byte. The first mismatch ends the run with fail and fail_addr. If there is no mismatch, pass is set.
- R7: A source fetch holds src_req high with src_addr equal to the current address until src_valid is high for one cycle, and src_data is captured in that cycle. A run that passes makes exactly two fetches per address.
- R8: busy is high from the cycle after an accepted start until the cycle in which done pulses. done is high for a single cycle, and exactly one of pass and fail is high with it. Both flags hold until the next start.
- R9: A start with length zero gives done and pass in the next cycle, with no strobe, no read and no fetch.
- R10: During reset busy, done, pass, fail, mem_strobe, mem_vpp and mem_vraise are low and mem_oe_n is high. start is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (sampled while idle) |
| base_addr | input | AW | First memory address of the run |
| length | input | AW+1 | Number of bytes to program |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Last run succeeded |
| fail | output | 1 | Last run failed |
| fail_addr | output | AW | Address that caused the failure |
| src_req | output | 1 | Source byte request |
| src_addr | output | AW | Address of the requested source byte |
| src_valid | input | 1 | Source byte present on src_data |
| src_data | input | 8 | Source byte |
| mem_addr | output | AW | Memory address |
| mem_dout | output | 8 | Byte driven to the memory for writing |
| mem_din | input | 8 | Byte read from the memory |
| mem_strobe | output | 1 | Write pulse |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_vpp | output | 1 | High-voltage enable |
| mem_vraise | output | 1 | Raised-supply flag |

## Verification
A wrong state in the sequencer shows up within one pulse period. A stuck or mis-loaded timer changes the strobe length or shortens the high-voltage window around it, and the strobe-edge monitors catch this at the next falling edge. A pulse counter that is not cleared between addresses, or one that compares against the wrong limit, changes the total number of strobes and moves the address where a weak byte is declared failed. An error in the nominal-supply pass shows as a wrong source-fetch count or a missed margin defect, and this is seen at the done pulse of the same run.

// File: rtl/pvs_pkg.sv
`timescale 1ns/1ps
package pvs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_READ,
        ST_CREAD
    } pvs_state_e;
endpackage

// File: rtl/pvs_timer.sv
`timescale 1ns/1ps
module pvs_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/pvs_retry.sv
`timescale 1ns/1ps
module pvs_retry #(
    parameter int LIMIT = 25,
    localparam int RW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    logic [RW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc && cnt_q != RW'(LIMIT))
            cnt_d = cnt_q + RW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign at_limit = (cnt_q == RW'(LIMIT));
endmodule

// File: rtl/pvs_seq.sv
`timescale 1ns/1ps
module pvs_seq #(
    parameter int AW        = 16,
    parameter int CLK_MHZ   = 200,
    parameter int PULSE_US  = 50,
    parameter int SETUP_US  = 2,
    parameter int RD_CYC    = 3,
    parameter int RETRY_MAX = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base_addr,
    input  logic [AW:0]   length,
    output logic          busy,
    output logic          done,
    output logic          pass,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic          src_req,
    output logic [AW-1:0] src_addr,
    input  logic          src_valid,
    input  logic [7:0]    src_data,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_dout,
    input  logic [7:0]    mem_din,
    output logic          mem_strobe,
    output logic          mem_oe_n,
    output logic          mem_vpp,
    output logic          mem_vraise
);
    import pvs_pkg::*;

    localparam int LW        = AW + 1;
    localparam int PULSE_CYC = CLK_MHZ * PULSE_US;
    localparam int SETUP_CYC = CLK_MHZ * SETUP_US;
    localparam int TMAX      = (PULSE_CYC > SETUP_CYC) ?
                               ((PULSE_CYC > RD_CYC) ? PULSE_CYC : RD_CYC) :
                               ((SETUP_CYC > RD_CYC) ? SETUP_CYC : RD_CYC);
    localparam int TW        = $clog2(TMAX + 1);
    localparam logic [TW-1:0] PULSE_LD = TW'(PULSE_CYC - 1);
    localparam logic [TW-1:0] SETUP_LD = TW'(SETUP_CYC - 1);
    localparam logic [TW-1:0] RD_LD    = TW'(RD_CYC - 1);

    typedef struct packed {
        pvs_state_e    st;
        logic [AW-1:0] base;
        logic [AW-1:0] addr;
        logic [LW-1:0] len;
        logic [LW-1:0] rem;
        logic [7:0]    byte_v;
        logic          final_ph;
        logic          done;
        logic          pass;
        logic          fail;
        logic [AW-1:0] fail_addr;
    } regs_t;

    regs_t s_d, s_q;

    logic          tmr_load, tmr_exp;
    logic [TW-1:0] tmr_val;
    logic          rty_clr, rty_inc, rty_lim;
    logic          step_ok, step_bad, rd_match;

    pvs_timer #(.W(TW)) timer_i (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .expired(tmr_exp)
    );

    pvs_retry #(.LIMIT(RETRY_MAX)) retry_i (
        .clk(clk), .rst_n(rst_n), .clr(rty_clr),
        .inc(rty_inc), .at_limit(rty_lim)
    );

    assign rd_match = (mem_din == s_q.byte_v);

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        rty_clr  = 1'b0;
        rty_inc  = 1'b0;
        step_ok  = 1'b0;
        step_bad = 1'b0;

        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.base     = base_addr;
                    s_d.addr     = base_addr;
                    s_d.len      = length;
                    s_d.rem      = length;
                    s_d.pass     = 1'b0;
                    s_d.fail     = 1'b0;
                    s_d.final_ph = 1'b0;
                    if (length == '0) begin
                        s_d.pass = 1'b1;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.st = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (src_valid) begin
                    s_d.byte_v = src_data;
                    rty_clr    = 1'b1;
                    tmr_load   = 1'b1;
                    if (s_q.final_ph) begin
                        tmr_val = RD_LD;
                        s_d.st  = ST_CREAD;
                    end else begin
                        tmr_val = SETUP_LD;
                        s_d.st  = ST_SETUP;
                    end
                end
            end
            ST_SETUP: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    tmr_val  = PULSE_LD;
                    rty_inc  = 1'b1;
                    s_d.st   = ST_PULSE;
                end
            end
            ST_PULSE: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    tmr_val  = SETUP_LD;
                    s_d.st   = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    tmr_val  = RD_LD;
                    s_d.st   = ST_READ;
                end
            end
            ST_READ: begin
                if (tmr_exp) begin
                    if (rd_match) begin
                        step_ok = 1'b1;
                    end else if (rty_lim) begin
                        step_bad = 1'b1;
                    end else begin
                        tmr_load = 1'b1;
                        tmr_val  = SETUP_LD;
                        s_d.st   = ST_SETUP;
                    end
                end
            end
            ST_CREAD: begin
                if (tmr_exp) begin
                    if (rd_match) step_ok  = 1'b1;
                    else          step_bad = 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase

        if (step_ok) begin
            if (s_q.rem == LW'(1)) begin
                if (s_q.final_ph) begin
                    s_d.pass = 1'b1;
                    s_d.done = 1'b1;
                    s_d.st   = ST_IDLE;
                end else begin
                    s_d.final_ph = 1'b1;
                    s_d.addr     = s_q.base;
                    s_d.rem      = s_q.len;
                    s_d.st       = ST_FETCH;
                end
            end else begin
                s_d.addr = s_q.addr + AW'(1);
                s_d.rem  = s_q.rem - LW'(1);
                s_d.st   = ST_FETCH;
            end
        end

        if (step_bad) begin
            s_d.fail      = 1'b1;
            s_d.fail_addr = s_q.addr;
            s_d.done      = 1'b1;
            s_d.st        = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy       = (s_q.st != ST_IDLE);
    assign done       = s_q.done;
    assign pass       = s_q.pass;
    assign fail       = s_q.fail;
    assign fail_addr  = s_q.fail_addr;
    assign src_req    = (s_q.st == ST_FETCH);
    assign src_addr   = s_q.addr;
    assign mem_addr   = s_q.addr;
    assign mem_dout   = s_q.byte_v;
    assign mem_strobe = (s_q.st == ST_PULSE);
    assign mem_vpp    = (s_q.st == ST_SETUP) || (s_q.st == ST_PULSE) || (s_q.st == ST_HOLD);
    assign mem_oe_n   = !((s_q.st == ST_READ) || (s_q.st == ST_CREAD));
    assign mem_vraise = busy && !s_q.final_ph;
endmodule

// File: rtl/pvs_seq_chk.sv
`timescale 1ns/1ps
module pvs_seq_chk #(
    parameter int AW        = 16,
    parameter int PULSE_CYC = 10000,
    parameter int SETUP_CYC = 400,
    parameter int RETRY_MAX = 25
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          pass,
    input logic          fail,
    input logic          src_req,
    input logic          src_valid,
    input logic [AW-1:0] src_addr,
    input logic [AW-1:0] mem_addr,
    input logic          mem_strobe,
    input logic          mem_oe_n,
    input logic          mem_vpp,
    input logic          mem_vraise
);
    logic [31:0]   hi_cnt, hv_cnt, pls_cnt;
    logic [AW-1:0] addr_prev;
    logic          stb_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt    <= '0;
            hv_cnt    <= '0;
            pls_cnt   <= '0;
            addr_prev <= '0;
            stb_prev  <= 1'b0;
        end else begin
            hi_cnt    <= mem_strobe ? hi_cnt + 32'd1 : 32'd0;
            hv_cnt    <= mem_vpp ? hv_cnt + 32'd1 : 32'd0;
            addr_prev <= mem_addr;
            stb_prev  <= mem_strobe;
            if (!busy || mem_addr != addr_prev)
                pls_cnt <= '0;
            else if (mem_strobe && !stb_prev)
                pls_cnt <= pls_cnt + 32'd1;
        end
    end

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_strobe && stb_prev) |-> (hi_cnt == 32'(PULSE_CYC))); // R1
    AST_STROBE_NEEDS_HV: assert property (@(posedge clk) disable iff (!rst_n)
        mem_strobe |-> (mem_vpp && mem_vraise)); // R2
    AST_HV_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_strobe && !stb_prev) |-> (hv_cnt >= 32'(SETUP_CYC))); // R2
    AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_vpp && !mem_strobe)); // R3
    AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_strobe && !stb_prev) |-> (pls_cnt < 32'(RETRY_MAX))); // R4
    AST_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req && !src_valid) |=> (src_req && $stable(src_addr))); // R7
    AST_DONE_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pass != fail) && !busy); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
endmodule

bind pvs_seq pvs_seq_chk #(
    .AW(AW), .PULSE_CYC(PULSE_CYC), .SETUP_CYC(SETUP_CYC), .RETRY_MAX(RETRY_MAX)
) chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .pass(pass), .fail(fail),
    .src_req(src_req), .src_valid(src_valid), .src_addr(src_addr),
    .mem_addr(mem_addr), .mem_strobe(mem_strobe), .mem_oe_n(mem_oe_n),
    .mem_vpp(mem_vpp), .mem_vraise(mem_vraise)
);

// File: tb/pvs_seq_tb_top.sv
`timescale 1ns/1ps
module pvs_seq_tb_top;
    localparam int AW        = 8;
    localparam int CLK_MHZ   = 1;
    localparam int PULSE_CYC = 50;
    localparam int SETUP_CYC = 2;
    localparam int NVEC      = 8;

    // base, len, need, mode(0 none,1 stuck,2 drift), bad, exp_pass, exp_faddr, exp_pulses
    localparam logic [63:0] VEC [NVEC] = '{
        64'h10_04_01_00_00_01_00_04,
        64'h20_03_03_00_00_01_00_09,
        64'h30_01_19_00_00_01_00_19,
        64'h40_02_1A_00_00_00_40_19,
        64'h50_04_01_01_52_00_52_1B,
        64'h60_03_02_02_62_00_62_06,
        64'h70_03_0A_00_00_01_00_1E,
        64'hF0_00_01_00_00_01_00_00
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [AW:0]   length = '0;
    logic          busy, done, pass, fail, src_req, mem_strobe, mem_oe_n, mem_vpp, mem_vraise;
    logic [AW-1:0] fail_addr, src_addr, mem_addr;
    logic          src_valid = 1'b0;
    logic [7:0]    src_data = '0;
    logic [7:0]    mem_dout, mem_din;

    always #2.5 clk = ~clk;

    pvs_seq #(.AW(AW), .CLK_MHZ(CLK_MHZ), .PULSE_US(50), .SETUP_US(2),
              .RD_CYC(3), .RETRY_MAX(25)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .length(length),
        .busy(busy), .done(done), .pass(pass), .fail(fail), .fail_addr(fail_addr),
        .src_req(src_req), .src_addr(src_addr), .src_valid(src_valid), .src_data(src_data),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_din(mem_din), .mem_strobe(mem_strobe),
        .mem_oe_n(mem_oe_n), .mem_vpp(mem_vpp), .mem_vraise(mem_vraise)
    );

    function automatic logic [7:0] src_fn(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ 8'h30;
    endfunction

    int n_chk = 0, n_err = 0, mon_chk = 0, mon_err = 0;
    logic       mem_clr = 1'b0;
    int         cur_need = 1, cur_mode = 0;
    logic [7:0] cur_bad = '0;
    logic [7:0] mem [256];
    int         cnt_p [256];
    int         tot_pulses = 0, fetches = 0, rd_cnt = 0, rd_viol = 0;
    int         hi_run = 0, hv_run = 0, hold_run = 0, dly = 0;
    logic       hold_act = 1'b0, stb_prev = 1'b0;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic mchk(input logic ok, input string req, input int act, input int exp);
        mon_chk++;
        if (!ok) begin
            mon_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // memory model: cells take cur_need pulses to program; mode 1 never programs cur_bad;
    // mode 2 flips bit 2 of cur_bad when read at nominal supply
    always_comb begin
        logic [7:0] v;
        v = mem[mem_addr];
        if (cur_mode == 2 && !mem_vraise && mem_addr == cur_bad) v = v ^ 8'h04;
        mem_din = mem_oe_n ? 8'hFF : v;
    end

    always @(negedge clk) begin
        if (mem_clr) begin
            for (int i = 0; i < 256; i++) begin
                mem[i]   = 8'hFF;
                cnt_p[i] = 0;
            end
            tot_pulses = 0;
        end else begin
            if (mem_strobe && !stb_prev)
                mchk(hv_run >= SETUP_CYC, "R2 hv setup before strobe", hv_run, SETUP_CYC);
            if (mem_strobe) hi_run++;
            if (!mem_strobe && stb_prev) begin
                mchk(hi_run == PULSE_CYC, "R1 strobe width", hi_run, PULSE_CYC);
                hi_run = 0;
                tot_pulses++;
                cnt_p[mem_addr]++;
                if (cnt_p[mem_addr] >= cur_need && !(cur_mode == 1 && mem_addr == cur_bad))
                    mem[mem_addr] = mem[mem_addr] & mem_dout;
                hold_act = 1'b1;
                hold_run = 0;
            end
            if (hold_act) begin
                if (mem_vpp) hold_run++;
                else begin
                    mchk(hold_run >= SETUP_CYC, "R2 hv hold after strobe", hold_run, SETUP_CYC);
                    hold_act = 1'b0;
                end
            end
            hv_run = mem_vpp ? hv_run + 1 : 0;
            if (!mem_oe_n) begin
                rd_cnt++;
                if (mem_vpp || mem_strobe) rd_viol++;
            end
            stb_prev = mem_strobe;
        end
    end

    // source responder: two cycles of latency, one-cycle valid
    always @(negedge clk) begin
        if (mem_clr) fetches = 0;
        if (src_valid) begin
            src_valid = 1'b0;
            dly = 0;
        end else if (src_req) begin
            if (dly == 2) begin
                src_valid = 1'b1;
                src_data  = src_fn(src_addr);
                fetches++;
            end else dly++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", n_chk + mon_chk + 1, n_err + mon_err + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!busy, "R10 busy in reset", busy, 0);
        chk(!done && !pass && !fail, "R10 flags in reset", {done, pass, fail}, 0);
        chk(!mem_strobe && !mem_vpp && !mem_vraise, "R10 drives in reset",
            {mem_strobe, mem_vpp, mem_vraise}, 0);
        chk(mem_oe_n, "R10 oe_n in reset", mem_oe_n, 1);
        @(negedge clk) rst_n = 1'b1;

        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] b, ln, bad, fad;
            int nd, md, ep, ep_p, exp_f, wt;
            b    = VEC[v][63:56];
            ln   = VEC[v][55:48];
            nd   = int'(VEC[v][47:40]);
            md   = int'(VEC[v][39:32]);
            bad  = VEC[v][31:24];
            ep   = int'(VEC[v][23:16]);
            fad  = VEC[v][15:8];
            ep_p = int'(VEC[v][7:0]);
            @(posedge clk);
            cur_need = nd;
            cur_mode = md;
            cur_bad  = bad;
            mem_clr  = 1'b1;
            @(posedge clk);
            mem_clr  = 1'b0;
            @(negedge clk);
            base_addr = b;
            length    = {1'b0, ln};
            start     = 1'b1;
            @(negedge clk);
            start = 1'b0;
            if (ln != 0) chk(busy, "R8 busy after start", busy, 1);
            wt = 0;
            while (!done && wt < 20000) begin
                @(negedge clk);
                wt++;
                // R10: a start during a run must not disturb it
                if (v == 0 && wt == 100) begin
                    base_addr = 8'hC0;
                    length    = 9'd1;
                    start     = 1'b1;
                end else start = 1'b0;
            end
            chk(done, "R8 done pulse seen", done, 1);
            chk(!busy, "R8 busy low at done", busy, 0);
            chk(pass == ep[0], "R4 R6 R9 pass flag", pass, ep);
            chk(fail == !ep[0], "R4 R6 fail flag", fail, !ep[0]);
            if (!ep[0]) chk(fail_addr == fad, "R4 R6 fail_addr", fail_addr, fad);
            chk(tot_pulses == ep_p, "R4 R5 R9 total pulses", tot_pulses, ep_p);
            if (ep[0]) exp_f = 2 * ln;
            else if (md == 2) exp_f = ln + int'(bad - b) + 1;
            else exp_f = fetches;
            chk(fetches == exp_f, "R7 R9 fetch count", fetches, exp_f);
            if (ep[0] && ln != 0)
                chk(mem[b] == src_fn(b), "R4 programmed byte", mem[b], src_fn(b));
            @(negedge clk);
            chk(!done && (pass == ep[0]), "R8 done single, flag held", {done, pass}, ep);
        end
        chk(rd_cnt > 0 && rd_viol == 0, "R3 reads with hv and strobe low", rd_viol, 0);
        $display("CHECKS %0d ERRORS %0d", n_chk + mon_chk, n_err + mon_err);
        $finish;
    end
endmodule